// File: doc/BRIEF.md
# Multi-Sample Write FIFO

This block is a sample queue that sits between a wide producer and a narrow consumer. The producer delivers a bundle of 0 to `MAX_PUSH` samples in one clock. The consumer drains the queue one sample per clock through a valid/ready handshake. The depth is a parameter. The producer is told how much room is left through a free-space count, so it can decide before sending whether a bundle will fit.

Storage is a ring of `DEPTH` slots with an add pointer and a get pointer. A bundle lands in consecutive slots starting at the add pointer, with lane 0 first, and the add pointer then moves on by the bundle size. Each pop moves the get pointer on by one. The free-space value is derived from the distance between the two pointers. A bundle that does not fit, or that is larger than the lane count, is dropped as a whole, and an error pulse is raised.

Top module: `bundle_fifo`

## Requirements
- R1: After reset is released, `free_o` equals `DEPTH`, `empty_o` is 1, `full_o` is 0, `pop_valid_o` is 0 and `ovf_o` is 0.
- R2: A push (`push_i`=1) whose count `k` satisfies k ≤ `free_o` and k ≤ `MAX_PUSH` is accepted. Without a pop in the same cycle, `free_o` is lower by k in the next cycle.
- R3: A push whose count exceeds `free_o` at the start of the cycle is ignored. The stored samples and their order are unchanged, and `ovf_o` is 1 for exactly the following cycle.
- R4: `pop_valid_o` is 1 exactly when the queue holds at least one sample, and `pop_data_o` then shows the oldest sample. A pop happens when `pop_valid_o` and `pop_ready_i` are both 1, removes one sample, and raises `free_o` by 1 in the next cycle. At most one sample leaves per cycle.
- R5: When an accepted push of k samples and a pop happen in the same cycle, `free_o` changes by 1−k. Admission uses the free space before that cycle's pop.
- R6: Bundle lane j is `push_data_i[j*DW +: DW]`. Samples leave in the order lane 0, 1, …, k−1 of each bundle, bundle after bundle, and this order holds across the wrap of the pointers at `DEPTH`. `DEPTH` need not be a power of two.
- R7: With `push_i`=0, the value of `push_cnt_i` has no effect, and `ovf_o` stays 0. A push with count 0 is accepted and changes nothing.
- R8: `full_o` is 1 exactly when `free_o` is 0, and `empty_o` is 1 exactly when `free_o` equals `DEPTH`.
- R9: A push whose count is greater than `MAX_PUSH` is rejected like R3, even when `free_o` would allow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push request for this cycle |
| push_cnt_i | input | K_W | Number of lanes to push |
| push_data_i | input | MAX_PUSH*DW | Bundle lanes, lane 0 in the lowest bits |
| pop_ready_i | input | 1 | Consumer takes the head sample |
| pop_valid_o | output | 1 | Head sample available |
| pop_data_o | output | DW | Head sample |
| free_o | output | CNT_W | Free slots |
| empty_o | output | 1 | No samples stored |
| full_o | output | 1 | No free slots |
| ovf_o | output | 1 | One-cycle pulse after a rejected push |

## Verification
The properties allow any value on `push_cnt_i`, including counts above `MAX_PUSH` and counts above the free space. They also allow `pop_ready_i` to be high while the queue is empty, because that case has to be shown to cause no pop. The one thing they assume is that the control inputs are known in every cycle after reset. The stimulus meets this by driving every input from a defined value on each falling edge. It also sweeps every fill level against every count and pop combination, so pushes that fit, pushes that are too large and idle cycles all occur from every starting level.

// File: rtl/bundle_fifo_pkg.sv
package bundle_fifo_pkg;
  // ring index advance for a non power-of-two ring
  function automatic int unsigned ring_add(int unsigned base, int unsigned ofs, int unsigned size);
    return (base + ofs) % size;
  endfunction
endpackage

// File: rtl/bundle_fifo_ptr.sv
module bundle_fifo_ptr #(
  parameter int DEPTH  = 16,
  parameter int STEP_W = 4,
  localparam int PW = $clog2(2*DEPTH),
  localparam int SW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] step_i,
  output logic [PW-1:0]     ptr_o,
  output logic [SW-1:0]     slot_o
);
  logic [PW-1:0] ptr_q, ptr_d;
  int unsigned   sum;

  // pointer runs over 2*DEPTH so that full and empty differ
  always_comb begin
    sum = int'(ptr_q) + int'(step_i);
    if (sum >= 2*DEPTH) sum = sum - 2*DEPTH;
    ptr_d = PW'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o  = ptr_q;
  assign slot_o = (int'(ptr_q) >= DEPTH) ? SW'(int'(ptr_q) - DEPTH) : SW'(ptr_q);
endmodule

// File: rtl/bundle_fifo_store.sv
module bundle_fifo_store #(
  parameter int DW       = 32,
  parameter int DEPTH    = 16,
  parameter int MAX_PUSH = 12,
  localparam int SW  = $clog2(DEPTH),
  localparam int K_W = $clog2(MAX_PUSH+1)
) (
  input  logic                   clk_i,
  input  logic                   we_i,
  input  logic [K_W-1:0]         cnt_i,
  input  logic [SW-1:0]          base_i,
  input  logic [MAX_PUSH*DW-1:0] data_i,
  input  logic [SW-1:0]          rd_slot_i,
  output logic [DW-1:0]          rd_data_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [SW-1:0] lane_slot [MAX_PUSH];
  logic [MAX_PUSH-1:0] lane_en;

  for (genvar j = 0; j < MAX_PUSH; j++) begin : g_lane
    assign lane_slot[j] = SW'(bundle_fifo_pkg::ring_add(int'(base_i), j, DEPTH));
    assign lane_en[j]   = we_i && (j < int'(cnt_i));
  end

  // accepted lanes hit distinct slots since cnt never exceeds free space
  always_ff @(posedge clk_i) begin
    for (int j = 0; j < MAX_PUSH; j++) begin
      if (lane_en[j]) mem[lane_slot[j]] <= data_i[j*DW +: DW];
    end
  end

  assign rd_data_o = mem[rd_slot_i];
endmodule

// File: rtl/bundle_fifo.sv
module bundle_fifo #(
  parameter int DW       = 32,
  parameter int DEPTH    = 16,
  parameter int MAX_PUSH = 12,
  localparam int K_W   = $clog2(MAX_PUSH+1),
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  logic [K_W-1:0]         push_cnt_i,
  input  logic [MAX_PUSH*DW-1:0] push_data_i,
  input  logic                   pop_ready_i,
  output logic                   pop_valid_o,
  output logic [DW-1:0]          pop_data_o,
  output logic [CNT_W-1:0]       free_o,
  output logic                   empty_o,
  output logic                   full_o,
  output logic                   ovf_o
);
  localparam int PW = $clog2(2*DEPTH);
  localparam int SW = $clog2(DEPTH);

  logic [PW-1:0]  add_ptr, get_ptr;
  logic [SW-1:0]  add_slot, get_slot;
  logic [K_W-1:0] add_step;
  logic [0:0]     get_step;
  logic           accept, pop_fire, fits;
  int             used;
  logic           ovf_q;

  always_comb begin
    if (add_ptr >= get_ptr) used = int'(add_ptr) - int'(get_ptr);
    else                    used = int'(add_ptr) + 2*DEPTH - int'(get_ptr);
  end

  assign free_o  = CNT_W'(DEPTH - used);
  assign empty_o = (used == 0);
  assign full_o  = (used == DEPTH);

  // admission uses space before this cycle's pop
  assign fits     = (int'(push_cnt_i) <= MAX_PUSH) && (int'(push_cnt_i) <= DEPTH - used);
  assign accept   = push_i && fits;
  assign pop_fire = pop_ready_i && !empty_o;
  assign add_step = accept ? push_cnt_i : '0;
  assign get_step = pop_fire;

  bundle_fifo_ptr #(.DEPTH(DEPTH), .STEP_W(K_W)) i_add_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (add_step),
    .ptr_o  (add_ptr),
    .slot_o (add_slot)
  );

  bundle_fifo_ptr #(.DEPTH(DEPTH), .STEP_W(1)) i_get_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (get_step),
    .ptr_o  (get_ptr),
    .slot_o (get_slot)
  );

  bundle_fifo_store #(.DW(DW), .DEPTH(DEPTH), .MAX_PUSH(MAX_PUSH)) i_store (
    .clk_i     (clk_i),
    .we_i      (accept),
    .cnt_i     (push_cnt_i),
    .base_i    (add_slot),
    .data_i    (push_data_i),
    .rd_slot_i (get_slot),
    .rd_data_o (pop_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= push_i && !fits;
  end

  assign ovf_o       = ovf_q;
  assign pop_valid_o = !empty_o;
endmodule

// File: rtl/bundle_fifo_chk.sv
module bundle_fifo_chk #(
  parameter int DEPTH    = 16,
  parameter int MAX_PUSH = 12,
  parameter int K_W      = 4,
  parameter int CNT_W    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic [K_W-1:0]   push_cnt_i,
  input logic             pop_ready_i,
  input logic             pop_valid_o,
  input logic [CNT_W-1:0] free_o,
  input logic             empty_o,
  input logic             full_o,
  input logic             ovf_o
);
  logic ok_push, bad_push, pop_fire;
  assign ok_push  = push_i && int'(push_cnt_i) <= int'(free_o) && int'(push_cnt_i) <= MAX_PUSH;
  assign bad_push = push_i && !ok_push;
  assign pop_fire = pop_valid_o && pop_ready_i;

  // R2
  push_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_push && !pop_fire |=> int'(free_o) == int'($past(free_o)) - int'($past(push_cnt_i)));

  // R3
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_push && !pop_fire |=> ovf_o && $stable(free_o));

  // R4
  pop_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_fire && !ok_push |=> int'(free_o) == int'($past(free_o)) + 1);

  // R4
  no_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_valid_o);

  // R5
  push_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_push && pop_fire |=> int'(free_o) == int'($past(free_o)) + 1 - int'($past(push_cnt_i)));

  // R7
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i && !pop_fire |=> $stable(free_o) && !ovf_o);

  // R8
  flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o) && (full_o == (free_o == '0)));

  // R9
  oversize_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && int'(push_cnt_i) > MAX_PUSH |=> ovf_o);
endmodule

bind bundle_fifo bundle_fifo_chk #(
  .DEPTH(DEPTH), .MAX_PUSH(MAX_PUSH), .K_W(K_W), .CNT_W(CNT_W)
) i_bundle_fifo_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .push_cnt_i  (push_cnt_i),
  .pop_ready_i (pop_ready_i),
  .pop_valid_o (pop_valid_o),
  .free_o      (free_o),
  .empty_o     (empty_o),
  .full_o      (full_o),
  .ovf_o       (ovf_o)
);

// File: tb/test_bundle_fifo.sv
module test_bundle_fifo;
  localparam int DW    = 32;
  localparam int DEPTH = 13;
  localparam int MAXP  = 12;
  localparam int K_W   = $clog2(MAXP+1);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                push_i = 1'b0;
  logic [K_W-1:0]      push_cnt_i = '0;
  logic [MAXP*DW-1:0]  push_data_i = '0;
  logic                pop_ready_i = 1'b0;
  logic                pop_valid_o;
  logic [DW-1:0]       pop_data_o;
  logic [CNT_W-1:0]    free_o;
  logic                empty_o, full_o, ovf_o;

  int checks = 0;
  int errors = 0;
  int model[$];
  int seq = 1;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  bundle_fifo #(.DW(DW), .DEPTH(DEPTH), .MAX_PUSH(MAXP)) i_bundle_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .push_cnt_i(push_cnt_i),
    .push_data_i(push_data_i), .pop_ready_i(pop_ready_i), .pop_valid_o(pop_valid_o),
    .pop_data_o(pop_data_o), .free_o(free_o), .empty_o(empty_o), .full_o(full_o),
    .ovf_o(ovf_o)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic verify(string free_tag, string ovf_tag, bit exp_ovf);
    chk(free_tag, "free_o", free_o, DEPTH - model.size());
    chk("R8", "empty_o", empty_o, model.size() == 0);
    chk("R8", "full_o", full_o, model.size() == DEPTH);
    chk("R4", "pop_valid_o", pop_valid_o, model.size() != 0);
    if (model.size() != 0) chk("R6", "pop_data_o", pop_data_o, model[0]);
    chk(ovf_tag, "ovf_o", ovf_o, exp_ovf);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(bit push, int k, bit pop);
    bit acc, popf;
    push_i = push;
    push_cnt_i = K_W'(k);
    pop_ready_i = pop;
    for (int j = 0; j < MAXP; j++) push_data_i[j*DW +: DW] = DW'(seq + j);
    acc  = push && k <= MAXP && k <= DEPTH - model.size();
    popf = pop && model.size() != 0;
    @(negedge clk_i);
    if (popf) void'(model.pop_front());
    if (acc) for (int j = 0; j < k; j++) model.push_back(seq + j);
    seq += 16;
    verify((acc && popf) ? "R5" : (push ? "R2" : "R7"),
           (k > MAXP) ? "R9" : (push ? "R3" : "R7"), push && !acc);
    push_i = 1'b0;
    pop_ready_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", "free_o", free_o, DEPTH);
    chk("R1", "empty_o", empty_o, 1);
    chk("R1", "full_o", full_o, 0);
    chk("R1", "pop_valid_o", pop_valid_o, 0);
    chk("R1", "ovf_o", ovf_o, 0);

    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int k = 0; k < (1 << K_W); k++) begin
        for (int pu = 0; pu < 2; pu++) begin
          for (int p = 0; p < 2; p++) begin
            while (model.size() > lvl) step(0, 0, 1);
            while (model.size() < lvl)
              step(1, (lvl - model.size() > MAXP) ? MAXP : lvl - model.size(), 0);
            step(pu[0], k, p[0]);
            step(0, 0, 0); // R3/R7: no change after the tested cycle
          end
        end
      end
    end
    // R6 drain through the wrap, order preserved
    while (model.size() > 0) step(0, 0, 1);
    step(0, 0, 1);
    chk("R4", "pop_valid_o drained", pop_valid_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule